// File: doc/BRIEF.md
# Multi-mode serial bit-rate generator

This block sets the bit timing for one channel of a serial port. It divides the peripheral clock in three steps. A power-of-two prescaler comes first. Next is a divider by (N+1), where N is an 8-bit divisor that software writes. Last is a final divider whose factor depends on the operating mode. That factor is 32 in asynchronous mode and 4 in clocked synchronous mode. In smart card mode it is one of four selectable values. The block issues one single-cycle `bit_tick` per bit period. In synchronous mode it also issues a single-cycle `sclk_edge` pulse at each half of the bit period, and the serial-clock logic can toggle on that pulse.

The divisor, the mode, the prescaler select and the smart card factor select are copied into an active set. This copy happens on every cycle while the channel is disabled, and at each bit boundary while it runs. A change made in mid-bit therefore never shortens or stretches the bit in progress. The software view of the divisor (`divisor_q`) always shows the last value written. Each channel instantiates its own copy of the block, so the channels hold independent divisors.

Top module: `baud_rate_gen`

## Requirements
- R1: After reset, `divisor_q` reads 0xFF and the active divisor is 255. A channel that is enabled with no prior write therefore runs with N = 255.
- R2: A write (`wr_en` high for one cycle) makes `divisor_q` equal to `wr_data` on the next cycle. Writes are accepted at any time, including while the channel runs.
- R3: With `mode_sel` = 0 (asynchronous), and also for the spare code 3, the bit period is 32 × 2^e × (N+1) clocks. The exponent e is 0 when `cks` = 0 and 2·cks+1 when `cks` = 1..3.
- R4: With `mode_sel` = 1 (clocked synchronous), the bit period is 4 × 2^e × (N+1) clocks, with the same exponent e as in R3.
- R5: With `mode_sel` = 2 (smart card), the bit period is S × 2^e × (N+1) clocks. Here e is 1 when `cks` = 0 and 2·cks+2 when `cks` = 1..3. S is chosen by `sc_sel`: 0 gives 32, 1 gives 64, 2 gives 372, 3 gives 256.
- R6: `bit_tick` is high for exactly one cycle. The first tick arrives exactly one bit period after the first clock edge that samples `en` high, and each later tick follows one bit period after the previous one.
- R7: If the divisor is written while the channel runs, the bit period in progress completes at its old length. The new divisor applies from the next bit period.
- R8: While `en` is low, `bit_tick` and `sclk_edge` stay low and all counters are cleared. Re-enabling starts a full bit period from zero.
- R9: In synchronous mode, `sclk_edge` pulses half a bit period after each bit start and again together with each `bit_tick`. In the other modes it never pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Channel enable; low clears and holds the counters |
| wr_en | input | 1 | Divisor write strobe |
| wr_data | input | 8 | Divisor value to write |
| mode_sel | input | 2 | 0 asynchronous, 1 synchronous, 2 smart card, 3 as 0 |
| cks | input | 2 | Prescaler select n |
| sc_sel | input | 2 | Smart card factor select |
| divisor_q | output | 8 | Software view of the divisor |
| bit_tick | output | 1 | One-cycle pulse at each bit boundary |
| sclk_edge | output | 1 | One-cycle pulse at each half bit period in synchronous mode |

## Verification
The bench builds the block with its default parameters: an 8-bit divisor, a 9-bit final divider, and smart card factors of 32, 64, 372 and 256. With these defaults the bench runs every mode with every prescaler select and with N = 0 and 1. It also runs N = 255 with the smallest prescaler, from the reset value and by an explicit write. The non-power-of-two factor 372 is included, so the final divider is exercised at a limit that is not a simple mask.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

  typedef enum logic [1:0] {
    MODE_ASYNC = 2'd0,
    MODE_SYNC  = 2'd1,
    MODE_SCARD = 2'd2,
    MODE_SPARE = 2'd3
  } bg_mode_e;

  // exponent of the power-of-two prescaler, at most 8
  localparam int EXP_W = 4;
  localparam int PRE_W = 8;

  function automatic logic [EXP_W-1:0] prescale_exp(input bg_mode_e m, input logic [1:0] n);
    logic [EXP_W-1:0] e;
    e = (n == 2'd0) ? '0 : EXP_W'({n, 1'b1});
    if (m == MODE_SCARD) e = e + EXP_W'(1);
    return e;
  endfunction

endpackage

// File: rtl/bgen_stage.sv
// One counting stage: advances on step, returns to zero on clr or when idle.
module bgen_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         step,
  input  logic         clr,
  output logic [W-1:0] cnt_q
);

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt_q <= '0;
    else if (clr)     cnt_q <= '0;
    else if (step)    cnt_q <= cnt_q + W'(1);
  end

endmodule

// File: rtl/bgen_cfg.sv
// Divisor register (software view) plus the active configuration that the
// counters use; the active copy follows the live inputs while idle and is
// refreshed only at bit boundaries while running.
module bgen_cfg
  import baud_gen_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int FIN_W   = 9,
  parameter int ASYNC_F = 32,
  parameter int SYNC_F  = 4,
  parameter int SC_F0   = 32,
  parameter int SC_F1   = 64,
  parameter int SC_F2   = 372,
  parameter int SC_F3   = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             boundary,
  input  logic             wr_en,
  input  logic [DIV_W-1:0] wr_data,
  input  logic [1:0]       mode_sel,
  input  logic [1:0]       cks,
  input  logic [1:0]       sc_sel,
  output logic [DIV_W-1:0] divisor_q,
  output logic [DIV_W-1:0] act_div,
  output logic [EXP_W-1:0] act_exp,
  output logic [FIN_W-1:0] act_fin_max,
  output logic [FIN_W-1:0] act_fin_mid,
  output logic             act_sync
);

  bg_mode_e         mode_live;
  logic [DIV_W-1:0] div_next;
  int               factor;

  always_comb begin
    mode_live = bg_mode_e'(mode_sel);
    div_next  = wr_en ? wr_data : divisor_q;
    case (mode_live)
      MODE_SYNC:  factor = SYNC_F;
      MODE_SCARD: begin
        case (sc_sel)
          2'd0:    factor = SC_F0;
          2'd1:    factor = SC_F1;
          2'd2:    factor = SC_F2;
          default: factor = SC_F3;
        endcase
      end
      default:    factor = ASYNC_F;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        divisor_q <= '1;
    else if (wr_en) divisor_q <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_div     <= '1;
      act_exp     <= '0;
      act_fin_max <= FIN_W'(ASYNC_F - 1);
      act_fin_mid <= FIN_W'(ASYNC_F / 2 - 1);
      act_sync    <= 1'b0;
    end else if (!en || boundary) begin
      act_div     <= div_next;
      act_exp     <= prescale_exp(mode_live, cks);
      act_fin_max <= FIN_W'(factor - 1);
      act_fin_mid <= FIN_W'(factor / 2 - 1);
      act_sync    <= (mode_live == MODE_SYNC);
    end
  end

endmodule

// File: rtl/baud_rate_gen.sv
module baud_rate_gen
  import baud_gen_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int FIN_W   = 9,
  parameter int ASYNC_F = 32,
  parameter int SYNC_F  = 4,
  parameter int SC_F0   = 32,
  parameter int SC_F1   = 64,
  parameter int SC_F2   = 372,
  parameter int SC_F3   = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             wr_en,
  input  logic [DIV_W-1:0] wr_data,
  input  logic [1:0]       mode_sel,
  input  logic [1:0]       cks,
  input  logic [1:0]       sc_sel,
  output logic [DIV_W-1:0] divisor_q,
  output logic             bit_tick,
  output logic             sclk_edge
);

  localparam int SPAN_W = PRE_W + 1;

  logic [DIV_W-1:0]  act_div;
  logic [EXP_W-1:0]  act_exp;
  logic [FIN_W-1:0]  act_fin_max;
  logic [FIN_W-1:0]  act_fin_mid;
  logic              act_sync;

  logic [SPAN_W-1:0] pre_span;
  logic [PRE_W-1:0]  pre_lim;
  logic [PRE_W-1:0]  pre_cnt;
  logic [DIV_W-1:0]  n_cnt;
  logic [FIN_W-1:0]  f_cnt;
  logic              pre_wrap, n_wrap, f_wrap, half_hit;

  bgen_cfg #(
    .DIV_W(DIV_W), .FIN_W(FIN_W), .ASYNC_F(ASYNC_F), .SYNC_F(SYNC_F),
    .SC_F0(SC_F0), .SC_F1(SC_F1), .SC_F2(SC_F2), .SC_F3(SC_F3)
  ) i_cfg (
    .clk(clk), .rst(rst), .en(en), .boundary(f_wrap),
    .wr_en(wr_en), .wr_data(wr_data), .mode_sel(mode_sel), .cks(cks), .sc_sel(sc_sel),
    .divisor_q(divisor_q), .act_div(act_div), .act_exp(act_exp),
    .act_fin_max(act_fin_max), .act_fin_mid(act_fin_mid), .act_sync(act_sync)
  );

  always_comb begin
    pre_span = SPAN_W'(1) << act_exp;
    pre_lim  = PRE_W'(pre_span - SPAN_W'(1));
    pre_wrap = en && (pre_cnt == pre_lim);
    n_wrap   = pre_wrap && (n_cnt == act_div);
    f_wrap   = n_wrap && (f_cnt == act_fin_max);
    half_hit = act_sync && n_wrap && (f_cnt == act_fin_mid);
  end

  bgen_stage #(.W(PRE_W)) i_pre (
    .clk(clk), .rst(rst), .run(en), .step(1'b1), .clr(pre_wrap), .cnt_q(pre_cnt)
  );

  bgen_stage #(.W(DIV_W)) i_ndiv (
    .clk(clk), .rst(rst), .run(en), .step(pre_wrap), .clr(n_wrap), .cnt_q(n_cnt)
  );

  bgen_stage #(.W(FIN_W)) i_fdiv (
    .clk(clk), .rst(rst), .run(en), .step(n_wrap), .clr(f_wrap), .cnt_q(f_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_tick  <= 1'b0;
      sclk_edge <= 1'b0;
    end else begin
      bit_tick  <= f_wrap;
      sclk_edge <= act_sync && (f_wrap || half_hit);
    end
  end

endmodule

// File: rtl/bgen_checker.sv
module bgen_checker #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             wr_en,
  input logic [DIV_W-1:0] wr_data,
  input logic [DIV_W-1:0] divisor_q,
  input logic             bit_tick,
  input logic             sclk_edge,
  input logic             act_sync
);

  assert_reset_value_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> divisor_q == {DIV_W{1'b1}});

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && wr_en) |-> divisor_q == $past(wr_data));

  assert_divisor_holds_R2: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !wr_en) |-> $stable(divisor_q));

  assert_tick_single_R6: assert property (@(posedge clk) disable iff (rst)
    bit_tick |=> !bit_tick);

  assert_quiet_when_off_R8: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!bit_tick && !sclk_edge));

  assert_sclk_only_sync_R9: assert property (@(posedge clk) disable iff (rst)
    sclk_edge |-> $past(act_sync));

  assert_sclk_at_bit_R9: assert property (@(posedge clk) disable iff (rst)
    (bit_tick && $past(act_sync)) |-> sclk_edge);

endmodule

bind baud_rate_gen bgen_checker #(.DIV_W(DIV_W)) i_bgen_checker (
  .clk(clk), .rst(rst), .en(en), .wr_en(wr_en), .wr_data(wr_data),
  .divisor_q(divisor_q), .bit_tick(bit_tick), .sclk_edge(sclk_edge),
  .act_sync(act_sync)
);

// File: tb/test_baud_rate_gen.sv
module test_baud_rate_gen;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] mode_sel = '0;
  logic [1:0] cks = '0;
  logic [1:0] sc_sel = '0;
  logic [7:0] divisor_q;
  logic       bit_tick;
  logic       sclk_edge;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  int exp_q[$];
  string tag_q[$];
  bit cur_sync = 1'b0;

  always #10 clk = ~clk;

  baud_rate_gen i_baud_rate_gen (
    .clk(clk), .rst(rst), .en(en), .wr_en(wr_en), .wr_data(wr_data),
    .mode_sel(mode_sel), .cks(cks), .sc_sel(sc_sel),
    .divisor_q(divisor_q), .bit_tick(bit_tick), .sclk_edge(sclk_edge)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int period_of(input int m, input int n, input int s, input int dv);
    int f, e;
    if (m == 1)      f = 4;
    else if (m == 2) f = (s == 0) ? 32 : (s == 1) ? 64 : (s == 2) ? 372 : 256;
    else             f = 32;
    e = (n == 0) ? 0 : 2 * n + 1;
    if (m == 2) e = e + 1;
    return f * (1 << e) * (dv + 1);
  endfunction

  task automatic step_cycle();
    @(posedge clk);
    #1;
  endtask

  task automatic wait_drained();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // driver: configure while idle, push expectations, enable, wait, disable
  task automatic run_cfg(input int m, input int n, input int s, input int dv,
                         input bit do_wr, input string req);
    int p, ticks;
    p = period_of(m, n, s, dv);
    ticks = (p > 4000) ? 1 : 2;
    step_cycle();
    en = 1'b0;
    mode_sel = 2'(m);
    cks = 2'(n);
    sc_sel = 2'(s);
    cur_sync = (m == 1);
    if (do_wr) begin
      wr_en = 1'b1;
      wr_data = 8'(dv);
      step_cycle();
      wr_en = 1'b0;
      @(negedge clk);
      check(divisor_q == 8'(dv), "R2 write readback", int'(divisor_q), dv);
    end
    step_cycle();
    for (int i = 0; i < ticks; i++) begin
      exp_q.push_back(p);
      tag_q.push_back(req);
    end
    step_cycle();
    en = 1'b1;
    wait_drained();
    step_cycle();
    en = 1'b0;
    step_cycle();
  endtask

  // monitor: measure cycles between ticks and compare with the scoreboard
  bit prev_en = 1'b0;
  bit prev_tick = 1'b0;
  int cnt = 0;
  int half_cnt = -1;

  always @(negedge clk) begin
    if (rst) begin
      prev_en = 1'b0; cnt = 0; half_cnt = -1; prev_tick = 1'b0;
    end else begin
      if (prev_en) cnt++;
      else begin cnt = 0; half_cnt = -1; end
      if (bit_tick && prev_tick) check(1'b0, "R6 tick wider than one cycle", 1, 0);
      if (sclk_edge && !bit_tick) begin
        if (!cur_sync) check(1'b0, "R9 sclk pulse outside sync mode", 1, 0);
        else half_cnt = cnt;
      end
      if (bit_tick) begin
        if (!prev_en) check(1'b0, "R8 tick while disabled", 1, 0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected tick", cnt, 0);
        end else begin
          int ev;
          string tg;
          ev = exp_q.pop_front();
          tg = tag_q.pop_front();
          check(cnt == ev, tg, cnt, ev);
          if (cur_sync) begin
            check(sclk_edge == 1'b1, "R9 sclk with bit tick", int'(sclk_edge), 1);
            check(half_cnt == ev / 2, "R9 sclk at half period", half_cnt, ev / 2);
          end else begin
            check(sclk_edge == 1'b0, "R9 no sclk outside sync", int'(sclk_edge), 0);
          end
        end
        cnt = 0;
        half_cnt = -1;
      end
      prev_tick = bit_tick;
      prev_en = en;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      check(1'b0, "watchdog expired", cycles, 190000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) step_cycle();
    rst = 1'b0;
    @(negedge clk);
    check(divisor_q == 8'hFF, "R1 reset divisor", int'(divisor_q), 255);
    check(bit_tick == 1'b0, "R6 no tick after reset", int'(bit_tick), 0);
    check(sclk_edge == 1'b0, "R9 no sclk after reset", int'(sclk_edge), 0);

    // R1: reset value governs an unwritten channel
    run_cfg(0, 0, 0, 255, 1'b0, "R1 R3 async reset divisor");

    for (int n = 0; n < 4; n++)
      for (int dv = 0; dv < 2; dv++)
        run_cfg(0, n, 0, dv, 1'b1, "R3 async period");
    for (int n = 0; n < 4; n++)
      for (int dv = 0; dv < 2; dv++)
        run_cfg(1, n, 0, dv, 1'b1, "R4 sync period");
    run_cfg(1, 0, 0, 255, 1'b1, "R4 sync N=255");
    for (int n = 0; n < 4; n++)
      for (int dv = 0; dv < 2; dv++)
        run_cfg(2, n, 0, dv, 1'b1, "R5 smart card S=32");
    run_cfg(2, 0, 0, 255, 1'b1, "R5 smart card N=255");
    run_cfg(2, 0, 1, 0, 1'b1, "R5 smart card S=64");
    run_cfg(2, 0, 2, 0, 1'b1, "R5 smart card S=372");
    run_cfg(2, 1, 2, 1, 1'b1, "R5 smart card S=372 n=1");
    run_cfg(2, 0, 3, 0, 1'b1, "R5 smart card S=256");
    run_cfg(3, 0, 0, 0, 1'b1, "R3 spare mode code");

    // R7: divisor write mid-bit applies from the next bit
    step_cycle();
    mode_sel = 2'd0; cks = 2'd0; cur_sync = 1'b0;
    wr_en = 1'b1; wr_data = 8'd0;
    step_cycle();
    wr_en = 1'b0;
    step_cycle();
    exp_q.push_back(32); tag_q.push_back("R7 current bit keeps old length");
    exp_q.push_back(64); tag_q.push_back("R7 next bit uses new divisor");
    en = 1'b1;
    repeat (10) step_cycle();
    wr_en = 1'b1; wr_data = 8'd1;
    step_cycle();
    wr_en = 1'b0;
    @(negedge clk);
    check(divisor_q == 8'd1, "R2 write while running", int'(divisor_q), 1);
    wait_drained();
    step_cycle();
    en = 1'b0;

    // R8: disable mid-bit clears counters; re-enable gives a full period
    step_cycle();
    en = 1'b1;
    repeat (40) step_cycle();
    en = 1'b0;
    repeat (5) step_cycle();
    @(negedge clk);
    check(bit_tick == 1'b0 && sclk_edge == 1'b0, "R8 quiet while disabled",
          int'(bit_tick) + int'(sclk_edge), 0);
    step_cycle();
    exp_q.push_back(64); tag_q.push_back("R8 full period after re-enable");
    en = 1'b1;
    wait_drained();
    step_cycle();
    en = 1'b0;
    repeat (3) step_cycle();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule